// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block sits beside the control registers of a 32-bit core and turns an exception request into the register updates and the program-counter redirect that enter a handler. On the cycle that `exc_req` is high, it samples five things. The first is the kind of exception. The second is the address of the faulting instruction. The third is whether that instruction sits in a branch delay slot. The fourth is whether the fault was a translation miss. The fifth is the current control state: exception level, boot-vector select, interrupt-vector select, pending and enabled interrupt lines, vectored-interrupt enable, vector spacing and the exception base page.

One clock later, the block drives a one-cycle set of update strobes with their values. These are the handler address, the exception program counter and branch-delay flag, the exception code, and the exception-level set. Non-maskable interrupts and soft resets take a separate error path instead. That path updates the error program counter, sets the error level and the boot-vector select, and flags which of the two events occurred. The register file that owns these fields applies the strobes, and the fetch unit takes the redirect.

The block is a three-state machine:
- **ST_IDLE**: no entry in progress.
- **ST_GENERAL**: a general exception or an interrupt is being entered.
- **ST_ERRVEC**: the error path is being entered.

Every state moves on each clock as follows:
- **take_general**: `exc_req` with a general kind moves to ST_GENERAL.
- **take_errvec**: `exc_req` with the NMI or soft-reset kind moves to ST_ERRVEC.
- **drop**: no request, or a request with an unlisted kind, moves to ST_IDLE.

Back-to-back requests therefore give back-to-back entries.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, all outputs are zero.
- R2: An entry is presented, with `entry_valid` high, for exactly the cycle after a cycle in which `exc_req` was high with a listed kind. In any cycle after a cycle without `exc_req`, every output is zero.
- R3: For a general entry, `code_we` is high and `exc_code` equals the kind code. The kind codes are: interrupt 0, TLB modify 1, TLB load 2, TLB store 3, address error load 4, address error store 5, instruction bus error 6, data bus error 7, syscall 8, break 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, floating point 15, machine check 24, cache error 30. `code_we` and `errorepc_we` are never high together.
- R4: On a general entry whose request saw `status_exl` low, the following hold. `epc_we` and `set_exl` are high. `epc_val` is the faulting address minus 4 if `in_delay_slot` was high, and the faulting address otherwise. `bd_val` equals `in_delay_slot`. If `status_exl` was high, `epc_we`, `bd_val` and `set_exl` stay low.
- R5: The general base is 0xBFC00200 when `status_bev` is set, and `{ebase_page, 10'b0}` otherwise. Kinds without a special rule enter at base + 0x180.
- R6: TLB load (2) or TLB store (3) with `tlb_miss` high and `status_exl` low enters at base + 0x000. With `status_exl` high, or `tlb_miss` low, these kinds enter at base + 0x180.
- R7: An interrupt (kind 0) with `vec_int_en` low enters at base + 0x200 if `cause_iv` is set, and at base + 0x180 if it is clear.
- R8: An interrupt with `vec_int_en` high enters at base + 0x200 + v × `vec_spacing` × 32. Here v is the highest index from 7 down to 1 set in `irq_pending & irq_mask`, and v is 0 when none of those bits is set.
- R9: A cache error (kind 30) enters at 0xBFC00100 when `status_bev` is set, and at `{ebase_page, 10'b0}` + 0x20000100 otherwise.
- R10: Kind 29 (NMI) or kind 28 (soft reset) gives the following outputs:
  - `errorepc_we`, `set_erl` and `set_bev` are high.
  - `errorepc_val` is the faulting address, corrected for a delay slot as in R4.
  - `entry_pc` is 0xBFC00000.
  - `set_nmi` is high for kind 29 and `set_soft_reset` is high for kind 28.
  - `code_we` and `epc_we` are low.
- R11: A request with an unlisted kind (14, 16 to 23, 25 to 27, 31) is ignored. Every output is zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception request strobe |
| exc_kind | input | 5 | Exception kind code (see R3, R10) |
| exc_pc | input | 32 | Address of the faulting instruction |
| in_delay_slot | input | 1 | Faulting instruction is in a delay slot |
| tlb_miss | input | 1 | Translation found no matching entry |
| status_exl | input | 1 | Current exception level |
| status_bev | input | 1 | Boot exception vector select |
| cause_iv | input | 1 | Interrupts use the dedicated offset |
| vec_int_en | input | 1 | Vectored interrupts enabled |
| irq_pending | input | 8 | Pending interrupt lines |
| irq_mask | input | 8 | Interrupt enable mask |
| vec_spacing | input | 5 | Vector spacing in 32-byte units |
| ebase_page | input | 22 | Exception base, bits 31:10 |
| entry_valid | output | 1 | Entry presented this cycle |
| entry_pc | output | 32 | Handler address |
| epc_we | output | 1 | Write exception PC |
| epc_val | output | 32 | Exception PC value |
| bd_val | output | 1 | Branch-delay flag value (with `epc_we`) |
| set_exl | output | 1 | Set exception level |
| code_we | output | 1 | Write exception code |
| exc_code | output | 5 | Exception code value |
| errorepc_we | output | 1 | Write error PC |
| errorepc_val | output | 32 | Error PC value |
| set_erl | output | 1 | Set error level |
| set_bev | output | 1 | Set boot-vector select |
| set_nmi | output | 1 | Error entry was an NMI |
| set_soft_reset | output | 1 | Error entry was a soft reset |

## Verification
A state register left in the wrong state shows one cycle after the request. It appears either as a missing or spurious `entry_valid` pulse, or as general strobes raised for an error-path kind, or the reverse. A wrong captured payload shows in the same cycle as a wrong `entry_pc`, `epc_val`, `bd_val` or `exc_code`. Wrong vector priority or spacing appears only on vectored interrupts, as an `entry_pc` off by a multiple of the spacing. For that reason the stimulus mixes pending and mask patterns with varied spacing, and compares every output on every clock.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GENERAL,
        ST_ERRVEC
    } entry_state_e;

    localparam logic [4:0] KIND_INT    = 5'd0;
    localparam logic [4:0] KIND_TLBL   = 5'd2;
    localparam logic [4:0] KIND_TLBS   = 5'd3;
    localparam logic [4:0] KIND_CACHE  = 5'd30;
    localparam logic [4:0] KIND_SRESET = 5'd28;
    localparam logic [4:0] KIND_NMI    = 5'd29;

    function automatic logic kind_general(input logic [4:0] k);
        case (k)
            5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9,
            5'd10, 5'd11, 5'd12, 5'd13, 5'd15, 5'd24, 5'd30: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic kind_errvec(input logic [4:0] k);
        return (k == KIND_NMI) || (k == KIND_SRESET);
    endfunction

endpackage

// File: rtl/exc_irq_vector.sv
module exc_irq_vector #(
    parameter int NUM_IP = 8,
    parameter int ID_W   = $clog2(NUM_IP)
) (
    input  logic [NUM_IP-1:0] masked,
    output logic [ID_W-1:0]   vec_id
);

    // Highest enabled line from the top down to line 1 wins; none gives 0.
    always_comb begin
        vec_id = '0;
        for (int i = 1; i < NUM_IP; i++) begin
            if (masked[i]) vec_id = i[ID_W-1:0];
        end
    end

    always_comb begin
        assert_vector_chosen_R8: assert (vec_id == '0 || masked[vec_id]);
    end

endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
    import exc_entry_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int VS_W      = 5,
    parameter int ID_W      = 3,
    parameter int EBASE_LSB = 10
) (
    input  logic [4:0]              kind,
    input  logic                    tlb_miss,
    input  logic                    status_exl,
    input  logic                    status_bev,
    input  logic                    cause_iv,
    input  logic                    vec_int_en,
    input  logic [ID_W-1:0]         vec_id,
    input  logic [VS_W-1:0]         vec_spacing,
    input  logic [ADDR_W-1:EBASE_LSB] ebase_page,
    output logic [ADDR_W-1:0]       handler_pc
);

    localparam logic [ADDR_W-1:0] BOOT_GENERAL = ADDR_W'(32'hBFC0_0200);
    localparam logic [ADDR_W-1:0] BOOT_CACHE   = ADDR_W'(32'hBFC0_0100);
    localparam logic [ADDR_W-1:0] ERR_VECTOR   = ADDR_W'(32'hBFC0_0000);
    localparam logic [ADDR_W-1:0] OFF_COMMON   = ADDR_W'(32'h0000_0180);
    localparam logic [ADDR_W-1:0] OFF_IRQ      = ADDR_W'(32'h0000_0200);
    localparam logic [ADDR_W-1:0] OFF_CACHE    = ADDR_W'(32'h2000_0100);
    localparam int               SPACE_SHIFT  = 5;

    logic [ADDR_W-1:0] ram_base;
    logic [ADDR_W-1:0] gen_base;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] vec_step;

    always_comb begin
        ram_base = {ebase_page, {EBASE_LSB{1'b0}}};
        gen_base = status_bev ? BOOT_GENERAL : ram_base;
        vec_step = ADDR_W'(vec_spacing) << SPACE_SHIFT;
        offset   = OFF_COMMON;
        if (kind == KIND_INT) begin
            if (vec_int_en)
                offset = OFF_IRQ + ADDR_W'(vec_id) * vec_step;
            else if (cause_iv)
                offset = OFF_IRQ;
        end else if ((kind == KIND_TLBL || kind == KIND_TLBS) && tlb_miss && !status_exl) begin
            offset = '0;
        end

        if (kind_errvec(kind))
            handler_pc = ERR_VECTOR;
        else if (kind == KIND_CACHE)
            handler_pc = status_bev ? BOOT_CACHE : ram_base + OFF_CACHE;
        else
            handler_pc = gen_base + offset;
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_IP     = 8,
    parameter int VS_W       = 5,
    parameter int EBASE_LSB  = 10,
    parameter int INSN_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      exc_req,
    input  logic [4:0]                exc_kind,
    input  logic [ADDR_W-1:0]         exc_pc,
    input  logic                      in_delay_slot,
    input  logic                      tlb_miss,
    input  logic                      status_exl,
    input  logic                      status_bev,
    input  logic                      cause_iv,
    input  logic                      vec_int_en,
    input  logic [NUM_IP-1:0]         irq_pending,
    input  logic [NUM_IP-1:0]         irq_mask,
    input  logic [VS_W-1:0]           vec_spacing,
    input  logic [ADDR_W-1:EBASE_LSB] ebase_page,
    output logic                      entry_valid,
    output logic [ADDR_W-1:0]         entry_pc,
    output logic                      epc_we,
    output logic [ADDR_W-1:0]         epc_val,
    output logic                      bd_val,
    output logic                      set_exl,
    output logic                      code_we,
    output logic [4:0]                exc_code,
    output logic                      errorepc_we,
    output logic [ADDR_W-1:0]         errorepc_val,
    output logic                      set_erl,
    output logic                      set_bev,
    output logic                      set_nmi,
    output logic                      set_soft_reset
);

    localparam int ID_W = $clog2(NUM_IP);

    entry_state_e      state_q, state_d;
    logic [ADDR_W-1:0] tgt_pc, resume_pc;
    logic [ADDR_W-1:0] pc_q, resume_q;
    logic              ds_q, exl_q, nmi_q;
    logic [4:0]        code_q;
    logic [ID_W-1:0]   vec_id;
    logic [NUM_IP-1:0] masked;

    assign masked    = irq_pending & irq_mask;
    assign resume_pc = in_delay_slot ? exc_pc - ADDR_W'(INSN_BYTES) : exc_pc;

    exc_irq_vector #(
        .NUM_IP (NUM_IP),
        .ID_W   (ID_W)
    ) u_vec (
        .masked (masked),
        .vec_id (vec_id)
    );

    exc_target_calc #(
        .ADDR_W    (ADDR_W),
        .VS_W      (VS_W),
        .ID_W      (ID_W),
        .EBASE_LSB (EBASE_LSB)
    ) u_tgt (
        .kind        (exc_kind),
        .tlb_miss    (tlb_miss),
        .status_exl  (status_exl),
        .status_bev  (status_bev),
        .cause_iv    (cause_iv),
        .vec_int_en  (vec_int_en),
        .vec_id      (vec_id),
        .vec_spacing (vec_spacing),
        .ebase_page  (ebase_page),
        .handler_pc  (tgt_pc)
    );

    // Next state: take_general, take_errvec or drop.
    always_comb begin
        if (exc_req && kind_general(exc_kind))
            state_d = ST_GENERAL;
        else if (exc_req && kind_errvec(exc_kind))
            state_d = ST_ERRVEC;
        else
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pc_q     <= '0;
            resume_q <= '0;
            ds_q     <= 1'b0;
            exl_q    <= 1'b0;
            nmi_q    <= 1'b0;
            code_q   <= '0;
        end else begin
            state_q <= state_d;
            if (exc_req) begin
                pc_q     <= tgt_pc;
                resume_q <= resume_pc;
                ds_q     <= in_delay_slot;
                exl_q    <= status_exl;
                nmi_q    <= (exc_kind == KIND_NMI);
                code_q   <= exc_kind;
            end
        end
    end

    always_comb begin
        entry_valid    = 1'b0;
        entry_pc       = '0;
        epc_we         = 1'b0;
        epc_val        = '0;
        bd_val         = 1'b0;
        set_exl        = 1'b0;
        code_we        = 1'b0;
        exc_code       = '0;
        errorepc_we    = 1'b0;
        errorepc_val   = '0;
        set_erl        = 1'b0;
        set_bev        = 1'b0;
        set_nmi        = 1'b0;
        set_soft_reset = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_GENERAL: begin
                entry_valid = 1'b1;
                entry_pc    = pc_q;
                code_we     = 1'b1;
                exc_code    = code_q;
                if (!exl_q) begin
                    epc_we  = 1'b1;
                    epc_val = resume_q;
                    bd_val  = ds_q;
                    set_exl = 1'b1;
                end
            end
            ST_ERRVEC: begin
                entry_valid    = 1'b1;
                entry_pc       = pc_q;
                errorepc_we    = 1'b1;
                errorepc_val   = resume_q;
                set_erl        = 1'b1;
                set_bev        = 1'b1;
                set_nmi        = nmi_q;
                set_soft_reset = !nmi_q;
            end
            default: ;
        endcase
    end

    assert_quiet_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |=> !entry_valid);

    assert_exl_blocks_epc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && status_exl) |=> (!epc_we && !set_exl && !bd_val));

    assert_single_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({code_we, errorepc_we}));

    assert_errvec_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        errorepc_we |-> (entry_pc == ADDR_W'(32'hBFC0_0000) && !code_we && !epc_we));

    assert_ignored_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !kind_general(exc_kind) && !kind_errvec(exc_kind)) |=> !entry_valid);

endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_kind = '0;
    logic [31:0] exc_pc = '0;
    logic        in_delay_slot = 1'b0, tlb_miss = 1'b0, status_exl = 1'b0;
    logic        status_bev = 1'b0, cause_iv = 1'b0, vec_int_en = 1'b0;
    logic [7:0]  irq_pending = '0, irq_mask = '0;
    logic [4:0]  vec_spacing = '0;
    logic [31:10] ebase_page = '0;

    logic        entry_valid, epc_we, bd_val, set_exl, code_we, errorepc_we;
    logic        set_erl, set_bev, set_nmi, set_soft_reset;
    logic [31:0] entry_pc, epc_val, errorepc_val;
    logic [4:0]  exc_code;

    always #4 clk = ~clk;

    exc_entry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_kind(exc_kind),
        .exc_pc(exc_pc), .in_delay_slot(in_delay_slot), .tlb_miss(tlb_miss),
        .status_exl(status_exl), .status_bev(status_bev), .cause_iv(cause_iv),
        .vec_int_en(vec_int_en), .irq_pending(irq_pending), .irq_mask(irq_mask),
        .vec_spacing(vec_spacing), .ebase_page(ebase_page),
        .entry_valid(entry_valid), .entry_pc(entry_pc), .epc_we(epc_we),
        .epc_val(epc_val), .bd_val(bd_val), .set_exl(set_exl), .code_we(code_we),
        .exc_code(exc_code), .errorepc_we(errorepc_we), .errorepc_val(errorepc_val),
        .set_erl(set_erl), .set_bev(set_bev), .set_nmi(set_nmi),
        .set_soft_reset(set_soft_reset)
    );

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // Reference expectations, refreshed at each edge.
    logic [31:0] e_pc, e_epc, e_eepc;
    logic        e_valid, e_epc_we, e_bd, e_exl, e_code_we, e_eepc_we;
    logic        e_erl, e_bev, e_nmi, e_sr;
    logic [4:0]  e_code;
    string       t_valid, t_pc, t_code, t_epc, t_err;

    int listed[$] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,15,24,30};

    function automatic bit is_listed(int k);
        foreach (listed[i]) if (listed[i] == k) return 1;
        return 0;
    endfunction

    task automatic clear_exp(string tag);
        e_valid = 0; e_pc = 0; e_epc_we = 0; e_epc = 0; e_bd = 0; e_exl = 0;
        e_code_we = 0; e_code = 0; e_eepc_we = 0; e_eepc = 0; e_erl = 0;
        e_bev = 0; e_nmi = 0; e_sr = 0;
        t_valid = tag; t_pc = tag; t_code = tag; t_epc = tag; t_err = tag;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clear_exp("R1");
        end else if (!exc_req) begin
            clear_exp("R2");
        end else begin
            longint base, resume, off;
            int k;
            k = int'(exc_kind);
            resume = in_delay_slot ? (longint'(exc_pc) - 4) : longint'(exc_pc);
            base = status_bev ? 64'hBFC00200 : longint'(ebase_page) * 1024;
            if (is_listed(k)) begin
                clear_exp("R2");
                e_valid = 1; e_code_we = 1; e_code = exc_kind; t_code = "R3";
                t_epc = "R4";
                if (!status_exl) begin
                    e_epc_we = 1; e_epc = resume[31:0]; e_bd = in_delay_slot; e_exl = 1;
                end
                off = 'h180; t_pc = "R5";
                if (k == 30) begin
                    t_pc = "R9";
                end else if (k == 0 && vec_int_en) begin
                    int v;
                    v = 0;
                    for (int i = 7; i >= 1; i--)
                        if (irq_pending[i] && irq_mask[i]) begin v = i; break; end
                    off = 'h200 + v * int'(vec_spacing) * 32; t_pc = "R8";
                end else if (k == 0) begin
                    off = cause_iv ? 'h200 : 'h180; t_pc = "R7";
                end else if (k == 2 || k == 3) begin
                    off = (tlb_miss && !status_exl) ? 0 : 'h180; t_pc = "R6";
                end
                if (k == 30)
                    e_pc = status_bev ? 32'hBFC00100 : 32'(longint'(ebase_page) * 1024 + 'h20000100);
                else
                    e_pc = 32'(base + off);
            end else if (k == 28 || k == 29) begin
                clear_exp("R10");
                e_valid = 1; e_pc = 32'hBFC00000; e_eepc_we = 1; e_eepc = resume[31:0];
                e_erl = 1; e_bev = 1; e_nmi = (k == 29); e_sr = (k == 28);
            end else begin
                clear_exp("R11");
            end
        end
    end

    task automatic chk(string tag, string name, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(t_valid, "entry_valid", 32'(entry_valid), 32'(e_valid));
        chk(t_pc, "entry_pc", entry_pc, e_pc);
        chk(t_epc, "epc_we", 32'(epc_we), 32'(e_epc_we));
        chk(t_epc, "epc_val", epc_val, e_epc);
        chk(t_epc, "bd_val", 32'(bd_val), 32'(e_bd));
        chk(t_epc, "set_exl", 32'(set_exl), 32'(e_exl));
        chk(t_code, "code_we", 32'(code_we), 32'(e_code_we));
        chk(t_code, "exc_code", 32'(exc_code), 32'(e_code));
        chk(t_err, "errorepc_we", 32'(errorepc_we), 32'(e_eepc_we));
        chk(t_err, "errorepc_val", errorepc_val, e_eepc);
        chk(t_err, "set_erl", 32'(set_erl), 32'(e_erl));
        chk(t_err, "set_bev", 32'(set_bev), 32'(e_bev));
        chk(t_err, "set_nmi", 32'(set_nmi), 32'(e_nmi));
        chk(t_err, "set_soft_reset", 32'(set_soft_reset), 32'(e_sr));
    endtask

    task automatic drive_random();
        int r;
        exc_req = ($urandom % 10) < 5;
        r = $urandom % 8;
        if (r == 0) exc_kind = 5'($urandom % 32);
        else if (r == 1) exc_kind = 5'(28 + ($urandom % 2));
        else if (r <= 3) exc_kind = 5'($urandom % 4);
        else exc_kind = 5'(listed[$urandom % listed.size()]);
        exc_pc        = $urandom & 32'hFFFF_FFFC;
        in_delay_slot = $urandom % 2;
        tlb_miss      = $urandom % 2;
        status_exl    = ($urandom % 3) == 0;
        status_bev    = $urandom % 2;
        cause_iv      = $urandom % 2;
        vec_int_en    = $urandom % 2;
        irq_pending   = 8'($urandom);
        irq_mask      = (($urandom % 4) == 0) ? 8'h01 : 8'($urandom);
        vec_spacing   = 5'($urandom);
        ebase_page    = 22'($urandom);
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            compare_all();   // R1 during reset
        end
        rst_n = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            compare_all();
            if (i == 2000) begin
                rst_n = 1'b0;   // R1 mid-run reset
                exc_req = 1'b1;
                @(negedge clk);
                compare_all();
                @(negedge clk);
                compare_all();
                rst_n = 1'b1;
                exc_req = 1'b0;
            end else begin
                drive_random();
            end
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule